// File: doc/BRIEF.md
# Two-Speed Resolver Angle Combiner

This block joins the readings of the two tracks of a two-speed resolver, whose coarse and fine tracks turn at a 1:32 ratio, into one 17-bit absolute shaft angle. The coarse track supplies a 6-bit field: its five most significant bits, plus one overlap bit. The fine track supplies a full 12-bit word. The combined word puts the five coarse bits on top of the twelve fine bits. The fine word therefore sets the resolution, and the coarse field only counts which of the 32 fine revolutions the shaft is in.

The two tracks are sampled by separate converters, so they do not cross a boundary at exactly the same moment. The lowest coarse bit taken in has the same weight as the most significant fine bit: one half of a fine revolution, 5.625 degrees of shaft. When these two bits disagree, one track has crossed a boundary before the other. The block trusts the fine track and moves the five-bit coarse count up or down by one, wrapping modulo 32. The result is registered and leaves the block one cycle after its valid input. A one-cycle flag marks every sample that needed a correction.

Top module: `angle_merge`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_fix` and `angle_out` are all zero.
- R2: `out_valid` equals `in_valid` from the previous clock cycle.
- R3: Bit positions are fixed. In `coarse_in`, bits [5:1] are the coarse count (bit 5 most significant) and bit 0 is the coarse overlap bit. Bit 11 of `fine_in` is the fine overlap bit. When a valid sample has equal overlap bits, `angle_out` one cycle later is `{coarse_in[5:1], fine_in}` and `out_fix` is 0.
- R4: A valid sample with coarse overlap 1 and fine overlap 0 yields `angle_out[16:12] = coarse_in[5:1] + 1 mod 32` and `out_fix` = 1 one cycle later. For example, 31 becomes 0.
- R5: A valid sample with coarse overlap 0 and fine overlap 1 yields `angle_out[16:12] = coarse_in[5:1] - 1 mod 32` and `out_fix` = 1 one cycle later. For example, 0 becomes 31.
- R6: For every valid sample, `angle_out[11:0]` one cycle later equals `fine_in` unchanged.
- R7: A cycle with `in_valid` low leaves `angle_out` at its previous value and drives `out_fix` to 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| coarse_in | input | 6 | Coarse count [5:1] and coarse overlap bit [0] |
| fine_in | input | 12 | Fine track angle; bit 11 is the overlap bit |
| out_valid | output | 1 | Output sample strobe, one cycle after `in_valid` |
| out_fix | output | 1 | High for a sample that had its coarse count corrected |
| angle_out | output | 17 | Combined absolute angle |

## Verification
The bench targets the wrap points of the coarse count. It sends an increment at count 31 and a decrement at count 0. A design that saturates at these points, or that widens the sum, would report 31 or 0 where 0 or 31 is due. It also sends both disagreeing overlap patterns with the two directions swapped, which exposes a design that inverts the correction sign. It sends agreeing patterns with the overlap bits both 0 and both 1, which exposes a design that corrects when it should not. Idle cycles placed between samples catch a design that lets `angle_out` follow the inputs while `in_valid` is low, or that leaves `out_fix` raised for a second cycle.

// File: rtl/angle_merge.sv
`timescale 1ns/1ps
module angle_merge #(
  parameter int KEEP_W = 5,
  parameter int FINE_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [KEEP_W:0]            coarse_in,
  input  logic [FINE_W-1:0]          fine_in,
  output logic                       out_valid,
  output logic                       out_fix,
  output logic [KEEP_W+FINE_W-1:0]   angle_out
);
  localparam int OUT_W = KEEP_W + FINE_W;
  localparam logic [KEEP_W-1:0] ONE = KEEP_W'(1);

  logic [KEEP_W-1:0] top_in, top_fix;
  logic ovl_c, ovl_f, ahead, behind;

  assign top_in = coarse_in[KEEP_W:1];
  assign ovl_c  = coarse_in[0];
  assign ovl_f  = fine_in[FINE_W-1];
  assign ahead  = ovl_c & ~ovl_f;
  assign behind = ~ovl_c & ovl_f;
  assign top_fix = ahead  ? top_in + ONE :
                   behind ? top_in - ONE : top_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fix   <= 1'b0;
      angle_out <= '0;
    end else begin
      out_valid <= in_valid;
      out_fix   <= in_valid & (ahead | behind);
      if (in_valid) angle_out <= {top_fix, fine_in};
    end
  end

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> (!out_valid && !out_fix && angle_out == '0));
  p_valid_r2: assert property (@(posedge clk) disable iff (!rst_n) out_valid == $past(in_valid) || $past(!rst_n));
  p_agree_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ovl_c == ovl_f) |=> (!out_fix && angle_out[OUT_W-1:FINE_W] == $past(top_in)));
  p_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ovl_c && !ovl_f) |=> (out_fix && angle_out[OUT_W-1:FINE_W] == $past(top_in) + ONE));
  p_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ovl_c && ovl_f) |=> (out_fix && angle_out[OUT_W-1:FINE_W] == $past(top_in) - ONE));
  p_fine_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> angle_out[FINE_W-1:0] == $past(fine_in));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(angle_out) && !out_fix));
endmodule

// File: tb/angle_merge_bench.sv
`timescale 1ns/1ps
module angle_merge_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [5:0] coarse_in = '0;
  logic [11:0] fine_in = '0;
  logic out_valid, out_fix;
  logic [16:0] angle_out;

  int checks = 0;
  int fails = 0;
  logic [18:0] q_exp[$];
  string q_tag[$];
  logic [16:0] model_ang = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  angle_merge u_angle_merge (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .coarse_in(coarse_in),
    .fine_in(fine_in), .out_valid(out_valid), .out_fix(out_fix), .angle_out(angle_out));

  task automatic drive(input logic [5:0] c, input logic [11:0] f, input logic v, input string tag);
    logic [4:0] top;
    logic fix;
    @(negedge clk);
    in_valid = v; coarse_in = c; fine_in = f;
    top = c[5:1];
    fix = 1'b0;
    if (v) begin
      if (c[0] && !f[11]) begin top = top + 5'd1; fix = 1'b1; end
      else if (!c[0] && f[11]) begin top = top - 5'd1; fix = 1'b1; end
      model_ang = {top, f};
    end
    q_exp.push_back({v, fix, model_ang});
    q_tag.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk); #2;
      if (q_exp.size() > 0) begin
        logic [18:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        checks++;
        if ({out_valid, out_fix, angle_out} !== e) begin
          fails++;
          $display("FAIL %s: got valid=%b fix=%b angle=%h, expected valid=%b fix=%b angle=%h",
                   t, out_valid, out_fix, angle_out, e[18], e[17], e[16:0]);
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (out_valid || out_fix || angle_out != '0) begin
      fails++;
      $display("FAIL R1: got valid=%b fix=%b angle=%h, expected 0 0 00000", out_valid, out_fix, angle_out);
    end
    @(negedge clk); rst_n = 1'b1;

    drive({5'd7, 1'b0}, 12'h123, 1'b1, "R3 agree low");
    drive({5'd9, 1'b1}, 12'hA5C, 1'b1, "R3 agree high");
    drive({5'd9, 1'b1}, 12'hA5C, 1'b0, "R2/R7 idle hold");
    drive({5'd3, 1'b1}, 12'h7FF, 1'b1, "R4 increment");
    drive({5'd31, 1'b1}, 12'h001, 1'b1, "R4 wrap 31->0");
    drive({5'd0, 1'b0}, 12'h800, 1'b0, "R7 idle ignores inputs");
    drive({5'd0, 1'b0}, 12'h800, 1'b1, "R5 wrap 0->31");
    drive({5'd20, 1'b0}, 12'hFFF, 1'b1, "R5 decrement");
    drive({5'd20, 1'b0}, 12'hFFF, 1'b0, "R7 fix drops");
    drive({5'd16, 1'b0}, 12'h000, 1'b1, "R6 fine zero");
    drive({5'd15, 1'b1}, 12'hFFF, 1'b1, "R6 fine ones");
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[5:0], {lfsr[15:8] ^ lfsr[7:0], lfsr[11:8]}, lfsr[3] | lfsr[9], "R2-mixed R3 R4 R5 R6 R7");
    end
    drive('0, '0, 1'b0, "R2 final idle");
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule